// File: doc/BRIEF.md
# SCSI Information-Transfer Length Controller

This block governs the length and the end of a single information-transfer phase in a SCSI host adapter. Software writes a 16-bit transfer count one byte at a time into two staging registers. A command that uses DMA then copies the staged value into the readable counter. A start strobe opens a burst. The burst length is the smaller of the programmed count and a limit that depends on the phase: 32 bytes while command bytes are moved, and the magnitude of the phase's remaining byte count in a data phase. A programmed count of zero stands for 65536 bytes.

Bytes move over an external request/acknowledge handshake. The block asserts its request only while the external DMA-enable input is high. A start that arrives while DMA is disabled waits until the enable returns. Each accepted byte lowers the readable counter by one, so software can read the residual count. When the transfer ends, the block sets the terminal-count and bus-service flags, raises the interrupt, clears the readable counter, and pulses a clear to the neighbouring sequence-step and FIFO-flag registers. A device-to-host burst that stops on the phase limit with count still left does not complete until the data source signals the end of the phase.

Top module: `xfer_len_ctrl`

## Requirements
- R1: Staging writes alone leave the readable counter unchanged. `dma_cmd` in idle sets the readable counter to {staged middle byte as bits 15:8, staged low byte as bits 7:0}. A staged value of zero reads back as 0 and counts as 65536.
- R2: A start strobe accepted in idle clears `tc_flag` on the next cycle and makes `busy` high.
- R3: In the command phase (`cmd_phase`=1) exactly min(count, 32) bytes are accepted.
- R4: In a data phase exactly min(count, |phase_left|) bytes are accepted.
- R5: `to_dev` becomes 1 when the burst is launched in the command phase or with a negative `phase_left`, otherwise 0, and it holds for the whole transfer.
- R6: `dma_req` is high only while `dma_en` is high and a burst has bytes left. A start given while `dma_en` is low stays pending with no request until `dma_en` rises.
- R7: Each cycle with both `dma_req` and `dma_ack` high lowers the readable counter by one.
- R8: Completion sets `tc_flag`, `bs_flag` and `irq`, clears the readable counter, and pulses `seq_fifo_clr` for exactly one cycle.
- R9: A to-device burst, or one whose last byte uses up the count, completes in the cycle after its last byte. A device-to-host burst ended by the phase limit with count remaining stays busy without interrupt until `phase_end`.
- R10: A data-phase burst with `phase_left` = 0 completes without ever raising `dma_req`.
- R11: `intr_rd` clears `irq` and `bs_flag` and leaves `tc_flag` set.
- R12: `dma_cmd` and `xfer_go` have no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_lo_we | input | 1 | Write strobe for the low staged count byte |
| cnt_mid_we | input | 1 | Write strobe for the middle staged count byte |
| wdata | input | 8 | Host write data |
| dma_cmd | input | 1 | DMA-type command: load staged count into the readable counter |
| xfer_go | input | 1 | Transfer-information start strobe |
| cmd_phase | input | 1 | High while the bus is in the command phase |
| phase_left | input | 24 | Signed remaining byte count of the phase (negative means to device) |
| dma_en | input | 1 | External DMA enable |
| dma_ack | input | 1 | Byte accepted by the DMA engine |
| phase_end | input | 1 | Data source reports the end of the phase |
| intr_rd | input | 1 | Interrupt register read: acknowledge |
| dma_req | output | 1 | Byte transfer request |
| to_dev | output | 1 | Direction of the current burst (1 = to device) |
| busy | output | 1 | Transfer pending, moving or awaiting phase end |
| cnt_lo | output | 8 | Readable counter bits 7:0 |
| cnt_mid | output | 8 | Readable counter bits 15:8 |
| tc_flag | output | 1 | Terminal-count status |
| bs_flag | output | 1 | Bus-service interrupt cause |
| irq | output | 1 | Interrupt request |
| seq_fifo_clr | output | 1 | One-cycle clear for sequence-step and FIFO-flag registers |

## Verification
The assertions check the cycle-local rules on every clock: requests only with enable and while busy, a decrement of one per accepted byte, a steady direction during a burst, the completion pulse with its flags and cleared counter, and interrupt acknowledge. The burst lengths from the minimum rule, the 65536 case for a zero count, and the wait for `phase_end` span many cycles. These, along with the pending start and the ignored commands while busy, are shown only by the bench's scenarios against its reference model.

// File: rtl/xfer_len_pkg.sv
package xfer_len_pkg;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_PEND = 2'd1,
    XS_MOVE = 2'd2,
    XS_HOLD = 2'd3
  } xfer_state_e;

  localparam int unsigned CMD_BURST_MAX = 32;

endpackage

// File: rtl/xfer_count_regs.sv
module xfer_count_regs #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_we,
  input  logic             mid_we,
  input  logic [7:0]       wdata,
  input  logic             load_en,
  input  logic             dec_en,
  input  logic             clr_en,
  output logic [CNT_W:0]   cnt_eff,
  output logic [CNT_W-1:0] cnt_rd
);
  localparam int unsigned EFF_W = CNT_W + 1;
  localparam int unsigned MID_W = CNT_W - 8;

  logic [7:0]       stage_lo_q;
  logic [MID_W-1:0] stage_mid_q;
  logic [EFF_W-1:0] cnt_q;

  // zero programmed count stands for the full range
  function automatic logic [EFF_W-1:0] widen_count(input logic [CNT_W-1:0] w);
    if (w == '0) return EFF_W'(1) << CNT_W;
    return {1'b0, w};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_lo_q  <= '0;
      stage_mid_q <= '0;
    end else begin
      if (lo_we)  stage_lo_q  <= wdata;
      if (mid_we) stage_mid_q <= wdata[MID_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_en)  cnt_q <= '0;
    else if (load_en) cnt_q <= widen_count({stage_mid_q, stage_lo_q});
    else if (dec_en)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_eff = cnt_q;
  assign cnt_rd  = cnt_q[CNT_W-1:0];

endmodule

// File: rtl/xfer_burst_calc.sv
module xfer_burst_calc #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned REM_W   = 24,
  parameter int unsigned CMD_MAX = 32
) (
  input  logic                    cmd_phase,
  input  logic signed [REM_W-1:0] phase_left,
  input  logic [CNT_W:0]          cnt_eff,
  output logic [CNT_W:0]          burst_len,
  output logic                    dir_to_dev
);
  localparam int unsigned EFF_W = CNT_W + 1;
  localparam int unsigned CW    = (EFF_W > REM_W) ? EFF_W : REM_W;

  function automatic logic [CW-1:0] magnitude(input logic signed [REM_W-1:0] v);
    logic [REM_W-1:0] u;
    u = v;
    if (v[REM_W-1]) u = ~u + 1'b1;
    return CW'(u);
  endfunction

  function automatic logic [CW-1:0] smaller(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [CW-1:0] limit_w;
  logic [CW-1:0] len_w;

  always_comb begin
    limit_w    = cmd_phase ? CW'(CMD_MAX) : magnitude(phase_left);
    len_w      = smaller(CW'(cnt_eff), limit_w);
    burst_len  = len_w[EFF_W-1:0];
    dir_to_dev = cmd_phase | phase_left[REM_W-1];
  end

endmodule

// File: rtl/xfer_status.sv
module xfer_status (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic done_evt,
  input  logic intr_rd,
  output logic tc_flag,
  output logic bs_flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_flag <= 1'b0;
      bs_flag <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (start_evt) tc_flag <= 1'b0;
      if (intr_rd) begin
        bs_flag <= 1'b0;
        irq     <= 1'b0;
      end
      if (done_evt) begin
        tc_flag <= 1'b1;
        bs_flag <= 1'b1;
        irq     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/xfer_len_ctrl.sv
module xfer_len_ctrl
  import xfer_len_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned REM_W   = 24,
  parameter int unsigned CMD_MAX = CMD_BURST_MAX
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cnt_lo_we,
  input  logic                    cnt_mid_we,
  input  logic [7:0]              wdata,
  input  logic                    dma_cmd,
  input  logic                    xfer_go,
  input  logic                    cmd_phase,
  input  logic signed [REM_W-1:0] phase_left,
  input  logic                    dma_en,
  input  logic                    dma_ack,
  input  logic                    phase_end,
  input  logic                    intr_rd,
  output logic                    dma_req,
  output logic                    to_dev,
  output logic                    busy,
  output logic [7:0]              cnt_lo,
  output logic [CNT_W-9:0]        cnt_mid,
  output logic                    tc_flag,
  output logic                    bs_flag,
  output logic                    irq,
  output logic                    seq_fifo_clr
);
  localparam int unsigned EFF_W = CNT_W + 1;

  xfer_state_e      st_q, st_d;
  logic [EFF_W-1:0] cnt_eff;
  logic [EFF_W-1:0] burst_len;
  logic [EFF_W-1:0] left_q;
  logic [CNT_W-1:0] cnt_rd;
  logic             dir_q, dir_calc, clr_q;

  // named events, shared by the datapath and the checker
  logic start_evt, load_evt, launch_evt, byte_evt, last_byte, exhaust, done_evt;

  assign busy       = (st_q != XS_IDLE);
  assign start_evt  = xfer_go && (st_q == XS_IDLE);
  assign load_evt   = dma_cmd && (st_q == XS_IDLE);
  assign launch_evt = (st_q == XS_PEND) && dma_en;
  assign dma_req    = (st_q == XS_MOVE) && dma_en;
  assign byte_evt   = dma_req && dma_ack;
  assign last_byte  = byte_evt && (left_q == EFF_W'(1));
  assign exhaust    = (cnt_eff == EFF_W'(1));
  assign done_evt   = (launch_evt && (burst_len == '0))
                   || (last_byte && (dir_q || exhaust))
                   || ((st_q == XS_HOLD) && phase_end);

  xfer_count_regs #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_we   (cnt_lo_we),
    .mid_we  (cnt_mid_we),
    .wdata   (wdata),
    .load_en (load_evt),
    .dec_en  (byte_evt),
    .clr_en  (done_evt),
    .cnt_eff (cnt_eff),
    .cnt_rd  (cnt_rd)
  );

  xfer_burst_calc #(.CNT_W(CNT_W), .REM_W(REM_W), .CMD_MAX(CMD_MAX)) u_len (
    .cmd_phase  (cmd_phase),
    .phase_left (phase_left),
    .cnt_eff    (cnt_eff),
    .burst_len  (burst_len),
    .dir_to_dev (dir_calc)
  );

  xfer_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .done_evt  (done_evt),
    .intr_rd   (intr_rd),
    .tc_flag   (tc_flag),
    .bs_flag   (bs_flag),
    .irq       (irq)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      XS_IDLE: if (start_evt)  st_d = XS_PEND;
      XS_PEND: if (launch_evt) st_d = (burst_len == '0) ? XS_IDLE : XS_MOVE;
      XS_MOVE: if (last_byte)  st_d = (dir_q || exhaust) ? XS_IDLE : XS_HOLD;
      XS_HOLD: if (phase_end)  st_d = XS_IDLE;
      default:                 st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XS_IDLE;
      left_q <= '0;
      dir_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      clr_q <= done_evt;
      if (launch_evt) begin
        left_q <= burst_len;
        dir_q  <= dir_calc;
      end else if (byte_evt) begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign to_dev       = dir_q;
  assign cnt_lo       = cnt_rd[7:0];
  assign cnt_mid      = cnt_rd[CNT_W-1:8];
  assign seq_fifo_clr = clr_q;

endmodule

// File: rtl/xfer_len_ctrl_chk.sv
module xfer_len_ctrl_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_req,
  input logic             dma_ack,
  input logic             dma_en,
  input logic             busy,
  input logic             to_dev,
  input logic             xfer_go,
  input logic             intr_rd,
  input logic [CNT_W-1:0] cnt_rd,
  input logic             tc_flag,
  input logic             bs_flag,
  input logic             irq,
  input logic             seq_fifo_clr,
  input logic             done_evt
);

  assert_req_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_en && busy));

  assert_byte_decrements_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack) |=> (seq_fifo_clr || ((cnt_rd + CNT_W'(1)) == $past(cnt_rd))));

  assert_dir_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> $stable(to_dev));

  assert_start_clears_tc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && !busy) |=> (!tc_flag && busy));

  assert_done_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fifo_clr |-> (tc_flag && bs_flag && irq && (cnt_rd == '0)));

  assert_clr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fifo_clr |=> !seq_fifo_clr);

  assert_done_pulses_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> seq_fifo_clr);

  assert_ack_clears_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_rd && !done_evt) |=> (!irq && !bs_flag && (tc_flag == $past(tc_flag))));

endmodule

bind xfer_len_ctrl xfer_len_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dma_req      (dma_req),
  .dma_ack      (dma_ack),
  .dma_en       (dma_en),
  .busy         (busy),
  .to_dev       (to_dev),
  .xfer_go      (xfer_go),
  .intr_rd      (intr_rd),
  .cnt_rd       (cnt_rd),
  .tc_flag      (tc_flag),
  .bs_flag      (bs_flag),
  .irq          (irq),
  .seq_fifo_clr (seq_fifo_clr),
  .done_evt     (done_evt)
);

// File: tb/xfer_len_ctrl_test.sv
`timescale 1ns/1ps
module xfer_len_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_lo_we = 0, cnt_mid_we = 0, dma_cmd = 0, xfer_go = 0, cmd_phase = 0;
  logic [7:0] wdata = 0;
  logic signed [23:0] phase_left = 0;
  logic dma_en = 1, dma_ack = 0, phase_end = 0, intr_rd = 0;
  logic dma_req, to_dev, busy, tc_flag, bs_flag, irq, seq_fifo_clr;
  logic [7:0] cnt_lo, cnt_mid;

  always #2.5 clk = ~clk;

  xfer_len_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cnt_lo_we(cnt_lo_we), .cnt_mid_we(cnt_mid_we),
    .wdata(wdata), .dma_cmd(dma_cmd), .xfer_go(xfer_go), .cmd_phase(cmd_phase),
    .phase_left(phase_left), .dma_en(dma_en), .dma_ack(dma_ack),
    .phase_end(phase_end), .intr_rd(intr_rd), .dma_req(dma_req), .to_dev(to_dev),
    .busy(busy), .cnt_lo(cnt_lo), .cnt_mid(cnt_mid), .tc_flag(tc_flag),
    .bs_flag(bs_flag), .irq(irq), .seq_fifo_clr(seq_fifo_clr)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  // behavioural reference: 0 idle, 1 pending, 2 moving, 3 awaiting phase end
  int m_state = 0, m_cnt = 0, m_left = 0, m_wlo = 0, m_wmid = 0, m_acc = 0;
  bit m_dir = 0, m_tc = 0, m_bs = 0, m_irq = 0, m_clr = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int lim, len, lv;
    bit done;
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_left = 0; m_wlo = 0; m_wmid = 0;
      m_dir = 0; m_tc = 0; m_bs = 0; m_irq = 0; m_clr = 0;
    end else begin
      done = 0;
      m_clr = 0;
      case (m_state)
        0: begin
          if (dma_cmd) begin
            m_cnt = m_wmid * 256 + m_wlo;
            if (m_cnt == 0) m_cnt = 65536;
          end
          if (xfer_go) begin m_state = 1; m_tc = 0; end
        end
        1: if (dma_en) begin
          lv  = int'(phase_left);
          lim = cmd_phase ? 32 : (lv < 0 ? -lv : lv);
          len = (m_cnt < lim) ? m_cnt : lim;
          m_dir = cmd_phase || (lv < 0);
          if (len == 0) begin done = 1; m_state = 0; end
          else begin m_left = len; m_state = 2; end
        end
        2: if (dma_en && dma_ack) begin
          m_acc++;
          m_cnt--;
          m_left--;
          if (m_left == 0) begin
            if (m_dir || m_cnt == 0) begin done = 1; m_state = 0; end
            else m_state = 3;
          end
        end
        default: if (phase_end) begin done = 1; m_state = 0; end
      endcase
      if (intr_rd) begin m_irq = 0; m_bs = 0; end
      if (done) begin m_tc = 1; m_bs = 1; m_irq = 1; m_cnt = 0; m_clr = 1; end
      if (cnt_lo_we)  m_wlo  = wdata;
      if (cnt_mid_we) m_wmid = wdata;
    end
  end

  // per-cycle comparison, well after the edge
  always @(posedge clk) begin
    #2;
    if (!finished) begin
      check("R6 dma_req",      dma_req,      (m_state == 2 && dma_en) ? 1 : 0);
      check("R5 to_dev",       to_dev,       m_dir);
      check("R2 busy",         busy,         (m_state != 0) ? 1 : 0);
      check("R7 counter",      {cnt_mid, cnt_lo}, m_cnt % 65536);
      check("R8 tc_flag",      tc_flag,      m_tc);
      check("R11 bs_flag",     bs_flag,      m_bs);
      check("R11 irq",         irq,          m_irq);
      check("R8 seq_fifo_clr", seq_fifo_clr, m_clr);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic program_count(int v);
    cnt_lo_we = 1; wdata = v[7:0]; tick();
    cnt_lo_we = 0; cnt_mid_we = 1; wdata = v[15:8]; tick();
    cnt_mid_we = 0; dma_cmd = 1; tick();
    dma_cmd = 0;
  endtask

  task automatic start_xfer(bit cmdp, int left);
    cmd_phase = cmdp; phase_left = left[23:0]; xfer_go = 1; tick();
    xfer_go = 0;
  endtask

  task automatic wait_until(bit want_busy, int max_cycles);
    for (int i = 0; i < max_cycles && busy != want_busy; i++) tick();
  endtask

  task automatic ack_intr();
    intr_rd = 1; tick(); intr_rd = 0;
  endtask

  initial begin
    int base;
    tick(3);
    check("R8 reset irq", irq, 0);
    check("R2 reset busy", busy, 0);
    rst_n = 1;
    tick(2);

    // R1: staging alone leaves the counter
    cnt_lo_we = 1; wdata = 8'h05; tick(); cnt_lo_we = 0; tick();
    check("R1 staged only", {cnt_mid, cnt_lo}, 0);
    dma_cmd = 1; tick(); dma_cmd = 0;
    check("R1 loaded", {cnt_mid, cnt_lo}, 5);
    program_count(16'h1234);
    check("R1 byte order", {cnt_mid, cnt_lo}, 16'h1234);

    // R3: command phase limited to 32
    dma_ack = 1;
    program_count(64);
    base = m_acc;
    start_xfer(1, 0);
    check("R2 tc cleared", tc_flag, 0);
    wait_until(0, 200);
    tick();
    check("R3 cmd burst 32", m_acc - base, 32);
    check("R8 irq set", irq, 1);
    check("R8 counter cleared", {cnt_mid, cnt_lo}, 0);
    ack_intr();
    check("R11 irq cleared", irq, 0);
    check("R11 tc kept", tc_flag, 1);

    program_count(10);
    base = m_acc;
    start_xfer(1, 0);
    wait_until(0, 200); tick();
    check("R3 cmd burst small", m_acc - base, 10);
    ack_intr();

    // R4/R5: data to device
    program_count(100);
    base = m_acc;
    start_xfer(0, -20);
    tick(2);
    check("R5 to device", to_dev, 1);
    wait_until(0, 200); tick();
    check("R4 out burst", m_acc - base, 20);
    check("R9 to-device at once", irq, 1);
    ack_intr();

    // R9: device to host limited by phase
    program_count(100);
    base = m_acc;
    start_xfer(0, 8);
    tick(20);
    check("R4 in burst", m_acc - base, 8);
    check("R5 from device", to_dev, 0);
    check("R9 waiting busy", busy, 1);
    check("R9 no irq yet", irq, 0);
    check("R7 residual", {cnt_mid, cnt_lo}, 92);
    // R12: commands ignored while busy
    cnt_lo_we = 1; wdata = 8'd7; tick(); cnt_lo_we = 0;
    cnt_mid_we = 1; wdata = 8'd0; tick(); cnt_mid_we = 0;
    dma_cmd = 1; xfer_go = 1; tick(); dma_cmd = 0; xfer_go = 0;
    tick();
    check("R12 load ignored", {cnt_mid, cnt_lo}, 92);
    check("R12 go ignored", busy, 1);
    phase_end = 1; tick(); phase_end = 0;
    check("R9 done on phase end", irq, 1);
    ack_intr();

    // R9: device to host exhausting the count
    program_count(12);
    base = m_acc;
    start_xfer(0, 50);
    wait_until(0, 200); tick();
    check("R9 exhausted burst", m_acc - base, 12);
    check("R9 exhausted irq", irq, 1);
    ack_intr();

    // R6: pending until enable, request drops with enable
    dma_en = 0;
    program_count(20);
    base = m_acc;
    start_xfer(0, -100);
    tick(5);
    check("R6 pending busy", busy, 1);
    check("R6 no req", dma_req, 0);
    dma_en = 1; tick(4);
    dma_en = 0; tick(3);
    check("R6 req off", dma_req, 0);
    dma_en = 1;
    wait_until(0, 200); tick();
    check("R6 burst after enable", m_acc - base, 20);
    ack_intr();

    // intermittent acknowledge
    program_count(9);
    base = m_acc;
    start_xfer(0, -30);
    for (int i = 0; i < 40; i++) begin dma_ack = i[0]; tick(); end
    dma_ack = 1;
    wait_until(0, 50); tick();
    check("R7 gapped burst", m_acc - base, 9);
    ack_intr();

    // R10: empty data phase
    program_count(5);
    base = m_acc;
    start_xfer(0, 0);
    wait_until(0, 20); tick();
    check("R10 no bytes", m_acc - base, 0);
    check("R10 completes", irq, 1);
    ack_intr();

    // R1/R3: zero count means 65536
    program_count(0);
    check("R1 zero count reads 0", {cnt_mid, cnt_lo}, 0);
    base = m_acc;
    start_xfer(0, 300);
    tick(320);
    check("R4 full-range burst", m_acc - base, 300);
    check("R7 full-range residual", {cnt_mid, cnt_lo}, 65236);
    phase_end = 1; tick(); phase_end = 0;
    check("R8 done", irq, 1);
    ack_intr();

    tick(3);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule